// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an asynchronous static RAM of 32K bytes. The host offers one read or one write per handshake on a valid/ready request channel. The controller turns each accepted request into a sequence of memory strobes: active-low chip select, write enable and output enable. It holds the address steady for the whole access. It drives the bidirectional data bus only while a write pulse is active. When a read completes, the captured byte comes back with a single-cycle valid pulse.

Every phase length is a whole number of clocks, derived at elaboration from the clock period in nanoseconds and a speed grade of 55, 70 or 85 ns. Each nanosecond limit is divided by the period and rounded up, with a floor of one clock per phase. Output enable is never asserted together with write enable. A read is always followed by a quiet gap long enough for the memory's outputs to float. As a result, the controller and the memory never drive the data pins at the same time.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all three strobes are high, the data drivers are off, reqReady is high and rdValid is low until a request is accepted.
- R2: A read keeps memCsN and memOeN low with memWeN high for RD = ceil(G/T) clocks, where G is the speed grade in ns and T the clock period. The byte present on memDin in the last of those clocks appears on rdData. rdValid is high for exactly one clock, RD clocks after the accepting edge.
- R3: A write keeps memCsN and memWeN low together for WP = max(ceil(Wp/T), ceil(Dw/T)) clocks, with memDoe high and memDout unchanged throughout. Wp is 40/50/55 ns and Dw is 30/30/35 ns for grades 55/70/85.
- R4: memOeN is high in every clock in which memWeN is low or memDoe is high, so the bus never has two drivers.
- R5: After each read phase, chip select and output enable stay high for FL = ceil(Hz/T) clocks before the next request can be accepted. Hz is 20/25/30 ns for grades 55/70/85.
- R6: After each write pulse, chip select stays high for max(1, RD - WP) recovery clocks before the next request can be accepted.
- R7: memAddr changes only on an edge whose preceding clock had both memWeN and memOeN high.
- R8: reqReady is high only when the controller is idle, and a request is taken on a clock edge where reqValid and reqReady are both high. With reqValid held high, consecutive accepts are RD+FL+1 clocks apart after a read and WP+(recovery)+1 clocks apart after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 8 | Write byte |
| rdValid | output | 1 | One-clock pulse with the read byte |
| rdData | output | 8 | Read byte |
| memCsN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | 15 | Memory address |
| memDout | output | 8 | Data toward the memory |
| memDin | input | 8 | Data from the memory |
| memDoe | output | 1 | Drive enable for memDout |

## Verification
The hardest case to provoke from the ports is a read followed at once by a write. This is the point where the memory's outputs are still floating while the controller wants to start driving. The bench reaches it by holding reqValid high across alternating read and write requests, so every turnaround happens at the earliest cycle the controller allows. A bus model in the bench flags any clock in which memDoe is high while output enable is low. The model also measures each strobe run and the distance between accepts, checking both against arithmetic expectations.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_FLOAT,
    PH_WRITE,
    PH_RECOV
  } phase_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycle time of a grade; unknown grades use the slowest figures
  function automatic int gradeCycleNs(input int g);
    return (g == 55) ? 55 : (g == 70) ? 70 : 85;
  endfunction

  function automatic int gradePulseNs(input int g);
    return (g == 55) ? 40 : (g == 70) ? 50 : 55;
  endfunction

  function automatic int gradeSetupNs(input int g);
    return (g == 55) ? 30 : (g == 70) ? 30 : 35;
  endfunction

  function automatic int gradeFloatNs(input int g);
    return (g == 55) ? 20 : (g == 70) ? 25 : 30;
  endfunction

endpackage

// File: rtl/sram_bus_fsm.sv
module sram_bus_fsm
  import sram_bus_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 70
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t ctl
);

  localparam int RD_CYC  = atLeastOne(ceilDiv(gradeCycleNs(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int WP_CYC  = atLeastOne(maxOf(ceilDiv(gradePulseNs(SPEED_GRADE), CLK_PERIOD_NS),
                                            ceilDiv(gradeSetupNs(SPEED_GRADE), CLK_PERIOD_NS)));
  localparam int FL_CYC  = atLeastOne(ceilDiv(gradeFloatNs(SPEED_GRADE), CLK_PERIOD_NS));
  localparam int REC_CYC = atLeastOne(RD_CYC - WP_CYC);
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(FL_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] FL_LAST  = CNT_W'(FL_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  phase_t            phase, phaseNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic              csNq, weNq, oeNq, driveQ;
  logic              cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    cntNext   = cntDone ? '0 : cnt - 1'b1;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNext = reqWrite ? PH_WRITE : PH_READ;
          cntNext   = reqWrite ? WP_LAST : RD_LAST;
        end
      end
      PH_READ:  if (cntDone) begin phaseNext = PH_FLOAT; cntNext = FL_LAST;  end
      PH_FLOAT: if (cntDone) phaseNext = PH_IDLE;
      PH_WRITE: if (cntDone) begin phaseNext = PH_RECOV; cntNext = REC_LAST; end
      PH_RECOV: if (cntDone) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  // strobes registered from the next phase so they leave the block glitch free
  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      csNq   <= 1'b1;
      weNq   <= 1'b1;
      oeNq   <= 1'b1;
      driveQ <= 1'b0;
    end else begin
      phase  <= phaseNext;
      cnt    <= cntNext;
      csNq   <= !(phaseNext == PH_READ || phaseNext == PH_WRITE);
      weNq   <= (phaseNext != PH_WRITE);
      oeNq   <= (phaseNext != PH_READ);
      driveQ <= (phaseNext == PH_WRITE);
    end
  end

  assign reqReady    = (phase == PH_IDLE);
  assign ctl.csN     = csNq;
  assign ctl.weN     = weNq;
  assign ctl.oeN     = oeNq;
  assign ctl.drive   = driveQ;
  assign ctl.load    = (phase == PH_IDLE) && reqValid;
  assign ctl.capture = (phase == PH_READ) && cntDone;

endmodule

// File: rtl/sram_bus_dp.sv
module sram_bus_dp
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdDataQ <= memDin;
      rdValidQ <= ctl.capture;
    end
  end

  assign memAddr = addrQ;
  assign memDout = wdataQ;
  assign memDoe  = ctl.drive;
  assign rdValid = rdValidQ;
  assign rdData  = rdDataQ;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 70,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoe
);

  strobe_t ctl;

  sram_bus_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .SPEED_GRADE  (SPEED_GRADE)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  sram_bus_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDin  (memDin),
    .memAddr (memAddr),
    .memDout (memDout),
    .memDoe  (memDoe),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign memCsN = ctl.csN;
  assign memWeN = ctl.weN;
  assign memOeN = ctl.oeN;

endmodule

// File: rtl/sram_bus_chk.sv
module sram_bus_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rdValid,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDoe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout
);

  // R4
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!memWeN || memDoe) |-> memOeN);

  // R3
  write_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCsN && memDoe));

  // R3
  wdata_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && $past(!memWeN)) |-> $stable(memDout));

  // R7
  addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(memAddr) |-> ($past(memWeN) && $past(memOeN)));

  // R8
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCsN && memWeN && memOeN && !memDoe));

  // R2
  rdvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

endmodule

bind sram_bus_ctrl sram_bus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;

  localparam int T  = 10;
  localparam int G  = 70;
  // expectations from the requirement formulas (grade 70: pulse 50, setup 30, float 25)
  localparam int EXP_RD  = (G + T - 1) / T;
  localparam int EXP_WPA = (50 + T - 1) / T;
  localparam int EXP_WPB = (30 + T - 1) / T;
  localparam int EXP_WP  = (EXP_WPA > EXP_WPB) ? EXP_WPA : EXP_WPB;
  localparam int EXP_FL  = (25 + T - 1) / T;
  localparam int EXP_REC = (EXP_RD - EXP_WP < 1) ? 1 : EXP_RD - EXP_WP;
  localparam int GAP_RD  = EXP_RD + EXP_FL + 1;
  localparam int GAP_WR  = EXP_WP + EXP_REC + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid, memCsN, memWeN, memOeN, memDoe;
  logic [7:0]  rdData, memDout, memDin;
  logic [14:0] memAddr;

  int total = 0, bad = 0, cycCnt = 0;
  bit done = 0;

  sram_bus_ctrl i_sram_bus_ctrl (.*);

  always #(T/2) clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench memory model: 256 cells indexed by low byte, with full-address tag
  logic [7:0]  memData [0:255];
  logic [14:0] memTag  [0:255];
  wire rdActive = !memCsN && !memOeN && memWeN;
  assign memDin = rdActive ? ((memTag[memAddr[7:0]] == memAddr) ? memData[memAddr[7:0]]
                                                                 : ~memData[memAddr[7:0]]) : 8'h00;

  // expected reads
  logic [7:0] expQ [0:1023];
  int         accQ [0:1023];
  int wrIdx = 0, rdIdx = 0;

  int weRun = 0, rdRun = 0;
  logic [14:0] wrA, prevAddr = '0;
  logic [7:0]  wrD;
  logic prevWeN = 1'b1, prevOeN = 1'b1;

  always @(negedge clk) if (!rst && !done) begin
    if (memDoe && !memOeN) check("R4 contention", 1, 0);
    if (!memCsN && !memWeN) begin
      if (!memDoe) check("R3 drive during pulse", 0, 1);
      if (weRun != 0 && memDout != wrD) check("R3 data steady", memDout, wrD);
      weRun++; wrA = memAddr; wrD = memDout;
    end else if (weRun != 0) begin
      check("R3 write pulse width", weRun, EXP_WP);
      memData[wrA[7:0]] = wrD; memTag[wrA[7:0]] = wrA;
      weRun = 0;
    end
    if (rdActive) rdRun++;
    else if (rdRun != 0) begin
      check("R2 read phase width", rdRun, EXP_RD);
      rdRun = 0;
    end
    if (memAddr != prevAddr && !(prevWeN && prevOeN)) check("R7 address moved under strobe", 1, 0);
    if (rdValid) begin
      if (rdIdx < wrIdx) begin
        check("R2 read data", rdData, expQ[rdIdx]);
        check("R2 rdValid timing", cycCnt - accQ[rdIdx], EXP_RD);
        rdIdx++;
      end else check("R2 spurious rdValid", 1, 0);
    end
    prevAddr = memAddr; prevWeN = memWeN; prevOeN = memOeN;
  end

  int  prevAcc = 0;
  bit  prevW = 0, chain = 0;

  // called at a negedge; leaves reqValid high for back-to-back use
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    reqWrite = w; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (chain) begin
      if (prevW) check("R6 R8 write-to-next accept gap", cycCnt - prevAcc, GAP_WR);
      else       check("R5 R8 read-to-next accept gap",  cycCnt - prevAcc, GAP_RD);
    end
    check("R8 busy after accept", reqReady, 0);
    prevAcc = cycCnt; prevW = w; chain = 1;
    if (!w) begin
      expQ[wrIdx] = ((memTag[a[7:0]] == a) ? memData[a[7:0]] : 8'hxx);
      accQ[wrIdx] = cycCnt;
      wrIdx++;
    end
  endtask

  task automatic stopBurst();
    reqValid = 1'b0; chain = 0;
    repeat (GAP_RD + 2) @(negedge clk);
  endtask

  function automatic logic [14:0] sweepAddr(input int i);
    return {7'(i * 37), 8'(i)};
  endfunction

  function automatic logic [7:0] pat(input logic [14:0] a, input int pass);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'(pass * 8'h5A);
  endfunction

  // expected data for reads is taken from what the bench itself wrote
  logic [7:0] shadow [0:255];

  initial begin
    for (int i = 0; i < 256; i++) begin memData[i] = 8'h00; memTag[i] = 15'h7FFF; end
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check("R1 csN in reset", memCsN, 1);
    check("R1 weN in reset", memWeN, 1);
    check("R1 oeN in reset", memOeN, 1);
    check("R1 drivers off in reset", memDoe, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ready after reset", reqReady, 1);
    check("R1 rdValid low after reset", rdValid, 0);

    // pass 0: write sweep back-to-back, then read sweep back-to-back
    for (int i = 0; i < 255; i++) begin
      issue(1, sweepAddr(i), pat(sweepAddr(i), 0)); shadow[i] = pat(sweepAddr(i), 0);
    end
    issue(1, 15'h7FFF, 8'hC3);
    stopBurst();
    for (int i = 0; i < 255; i++) begin
      issue(0, sweepAddr(i), 8'h00);
      if (expQ[wrIdx-1] != shadow[i]) check("R3 stored byte", expQ[wrIdx-1], shadow[i]);
    end
    issue(0, 15'h7FFF, 8'h00);
    check("R3 top address stored", expQ[wrIdx-1], 8'hC3);
    stopBurst();

    // pass 1: alternate write/read on the same address, back-to-back turnarounds
    for (int i = 0; i < 64; i++) begin
      issue(1, sweepAddr(i * 3), pat(sweepAddr(i * 3), 1));
      issue(0, sweepAddr(i * 3), 8'h00);
      check("R2 read after write", expQ[wrIdx-1], pat(sweepAddr(i * 3), 1));
    end
    stopBurst();

    // isolated single operations with idle gaps
    issue(1, 15'h0000, 8'hFF); stopBurst();
    issue(0, 15'h0000, 8'h00); stopBurst();
    check("R2 zero address readback", expQ[wrIdx-1], 8'hFF);

    repeat (20) @(negedge clk);
    check("R2 every read returned", rdIdx, wrIdx);
    check("R1 idle strobes at end", {memCsN, memWeN, memOeN, memDoe}, 4'b1110);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule